// File: doc/BRIEF.md
# Flat Page Table Address Translator

This block turns a 32-bit device virtual address into a physical address by reading one descriptor from a single-level table held in memory. The table uses 4 KiB pages only. It has one 32-bit descriptor per page, so the table covers a 4 GiB space and is 4 MiB in size. A client puts a virtual address on the request port. The block fetches the matching descriptor over a simple read port and returns the result on the response port.

A descriptor is usable only when its valid flag is set. It also carries a flag that marks the page non-secure. When a translation fails, the physical address returned is not taken from the descriptor. It is redirected into a 128-byte-aligned protect area, so a faulting master never issues a stray access. There are two kinds of failure: the descriptor is not valid, or the table read returned an error. A control word chooses how the address inside the protect area is formed. The same control word also marks table reads as coherent. Only one translation is in flight at a time.

Top module: `flat_xlat`

## Requirements
- R1: While reset is active and in the cycle after it, `req_ready` is 1, and `rsp_valid` and `mem_rd_valid` are 0.
- R2: The read address is `cfg_table_base + 4*(vaddr >> 12)`, computed modulo 2^32. `mem_rd_coherent` follows bit 8 of `cfg_ctrl`.
- R3: A descriptor with bit 1 set produces `rsp_fault`=0 and `rsp_kind`=0. The returned address is descriptor bits [31:12] joined with vaddr bits [11:0].
- R4: For a valid descriptor, `rsp_nonsec` equals descriptor bit 3. On any fault, `rsp_nonsec` is 0.
- R5: A descriptor with bit 1 clear, including an all-zero descriptor, gives `rsp_fault`=1 and `rsp_kind`=1 (translation fault). The address is redirected as in R6.
- R6: On a fault, the protect address has its low 7 bits forced to 0. `cfg_ctrl` bits [6:5] then choose the returned address: 0 gives the aligned base; 1 gives the base plus vaddr[6:0]; 2 gives the base plus 128; 3 gives the base plus 128 plus vaddr[6:0].
- R7: When `mem_rsp_err` is 1 with the read data, the result is `rsp_fault`=1 and `rsp_kind`=2 (table-walk fault), redirected as in R6. This holds whatever the descriptor bits are.
- R8: `req_ready` stays 0 from the moment a request is accepted until its response is taken. Exactly one table read is issued per request. `mem_rd_valid` and `mem_rd_addr` are held until `mem_rd_ready`.
- R9: While `rsp_valid` is 1 and `rsp_ready` is 0, the response stays valid and all response fields are held.
- R10: Changing `cfg_table_base` after a request has been accepted does not change that request's read address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_table_base | input | 32 | Byte address of the descriptor table |
| cfg_protect_addr | input | 32 | Protect area address (low 7 bits ignored) |
| cfg_ctrl | input | 32 | Control: bit 8 coherent fetch, bits [6:5] protect mode |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_vaddr | input | 32 | Virtual address to translate |
| mem_rd_valid | output | 1 | Descriptor read request |
| mem_rd_ready | input | 1 | Memory accepts the read |
| mem_rd_addr | output | 32 | Descriptor byte address |
| mem_rd_coherent | output | 1 | Read must be coherent |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Descriptor word |
| mem_rsp_err | input | 1 | Read error |
| rsp_valid | output | 1 | Translation result valid |
| rsp_ready | input | 1 | Client takes the result |
| rsp_paddr | output | 32 | Physical or protect address |
| rsp_fault | output | 1 | Translation failed |
| rsp_kind | output | 2 | 0 none, 1 translation fault, 2 table-walk fault |
| rsp_nonsec | output | 1 | Page is non-secure |

## Verification
The translator is driven with several descriptor patterns:
- valid non-secure descriptors;
- valid secure descriptors;
- an all-zero descriptor;
- a descriptor with every bit set except the valid bit;
- a valid descriptor that comes back with a read error.

Together these separate the valid flag from the non-secure flag, and the translation fault from the table-walk fault. Virtual addresses at the bottom and top pages check the index scaling and the offset splice. One fault address is run under all four protect modes, and the protect base has nonzero low bits so that the forced alignment is visible. Stalls on both the read and the response ports, a second request held during a translation, and a base change in flight show the single-outstanding behaviour and the held values.

// File: rtl/flat_xlat_pkg.sv
// Shared constants and types for the flat page table translator.
// Assumes 32-bit addresses, 4 KiB pages and 32-bit descriptors.
package flat_xlat_pkg;
    localparam int ADDR_W        = 32;
    localparam int PAGE_SHIFT    = 12;
    localparam int DESC_W        = 32;
    localparam int DESC_BYTES    = DESC_W / 8;
    localparam int VALID_BIT     = 1;
    localparam int NONSEC_BIT    = 3;
    localparam int COHERENT_BIT  = 8;
    localparam int PMODE_LSB     = 5;
    localparam int PROTECT_ALIGN = 128;

    typedef enum logic [1:0] {
        FK_NONE  = 2'd0,
        FK_XLATE = 2'd1,
        FK_WALK  = 2'd2
    } fault_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_WAIT  = 2'd2,
        ST_RESP  = 2'd3
    } walk_state_e;

    typedef struct packed {
        logic [ADDR_W-1:0] paddr;
        fault_kind_e       kind;
        logic              nonsec;
    } xlat_result_t;
endpackage

// File: rtl/flat_pt_index.sv
// Computes the byte address of the descriptor that covers a virtual address.
// Assumes the table is contiguous and wraps modulo 2^ADDR_W.
module flat_pt_index #(
    parameter int ADDR_W     = flat_xlat_pkg::ADDR_W,
    parameter int PAGE_SHIFT = flat_xlat_pkg::PAGE_SHIFT,
    parameter int DESC_BYTES = flat_xlat_pkg::DESC_BYTES
) (
    input  logic [ADDR_W-1:0] table_base,
    input  logic [ADDR_W-1:0] vaddr,
    output logic [ADDR_W-1:0] desc_addr
);
    localparam int IDX_SHIFT = $clog2(DESC_BYTES);

    logic [ADDR_W-1:0] page_num;
    logic [ADDR_W-1:0] byte_off;

    // Scale the page number to a byte offset and add it to the base.
    always_comb begin
        page_num  = vaddr >> PAGE_SHIFT;
        byte_off  = page_num << IDX_SHIFT;
        desc_addr = table_base + byte_off;
    end
endmodule

// File: rtl/flat_pt_decode.sv
// Turns a fetched descriptor (or a read error) into a translation result.
// A fault redirects the address into an aligned protect area.
// Assumes pmode is the two-bit protect mode taken from the control word.
module flat_pt_decode
    import flat_xlat_pkg::*;
#(
    parameter int A_W   = ADDR_W,
    parameter int D_W   = DESC_W,
    parameter int PSH   = PAGE_SHIFT,
    parameter int ALIGN = PROTECT_ALIGN
) (
    input  logic [D_W-1:0] desc,
    input  logic           rd_err,
    input  logic [A_W-1:0] vaddr,
    input  logic [A_W-1:0] protect_addr,
    input  logic [1:0]     pmode,
    output xlat_result_t   result
);
    localparam int ALIGN_SH = $clog2(ALIGN);

    logic [A_W-1:0] prot_base;
    logic [A_W-1:0] prot_off;
    logic [A_W-1:0] prot_slot;
    logic [A_W-1:0] prot_final;
    logic [A_W-1:0] map_addr;
    logic           desc_ok;

    // Form the redirect address inside the protect area.
    always_comb begin
        prot_base  = {protect_addr[A_W-1:ALIGN_SH], {ALIGN_SH{1'b0}}};
        prot_off   = pmode[0] ? {{(A_W-ALIGN_SH){1'b0}}, vaddr[ALIGN_SH-1:0]} : '0;
        prot_slot  = pmode[1] ? A_W'(ALIGN) : '0;
        prot_final = prot_base + prot_slot + prot_off;
    end

    // Splice the frame number from the descriptor with the page offset.
    always_comb begin
        map_addr = {desc[D_W-1:PSH], vaddr[PSH-1:0]};
        desc_ok  = desc[VALID_BIT];
    end

    // Select mapped or redirected result; a read error wins over contents.
    always_comb begin
        if (rd_err) begin
            result.paddr  = prot_final;
            result.kind   = FK_WALK;
            result.nonsec = 1'b0;
        end else if (!desc_ok) begin
            result.paddr  = prot_final;
            result.kind   = FK_XLATE;
            result.nonsec = 1'b0;
        end else begin
            result.paddr  = map_addr;
            result.kind   = FK_NONE;
            result.nonsec = desc[NONSEC_BIT];
        end
    end
endmodule

// File: rtl/flat_pt_seq.sv
// Sequencer for one outstanding translation: accept, fetch, wait, respond.
// Captures the virtual address and descriptor address at acceptance,
// and the decoded result when read data returns.
module flat_pt_seq
    import flat_xlat_pkg::*;
#(
    parameter int A_W = ADDR_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           req_valid,
    output logic           req_ready,
    input  logic [A_W-1:0] req_vaddr,
    input  logic [A_W-1:0] desc_addr_in,
    output logic [A_W-1:0] held_vaddr,
    output logic           mem_rd_valid,
    input  logic           mem_rd_ready,
    output logic [A_W-1:0] mem_rd_addr,
    input  logic           mem_rsp_valid,
    input  xlat_result_t   decoded,
    output logic           rsp_valid,
    input  logic           rsp_ready,
    output xlat_result_t   rsp_q
);
    walk_state_e    state_q;
    logic [A_W-1:0] va_q;
    logic [A_W-1:0] daddr_q;

    // Advance the walk state on each handshake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            case (state_q)
                ST_IDLE:  if (req_valid)     state_q <= ST_FETCH;
                ST_FETCH: if (mem_rd_ready)  state_q <= ST_WAIT;
                ST_WAIT:  if (mem_rsp_valid) state_q <= ST_RESP;
                ST_RESP:  if (rsp_ready)     state_q <= ST_IDLE;
                default:                     state_q <= ST_IDLE;
            endcase
        end
    end

    // Capture request address and descriptor address at acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            va_q    <= '0;
            daddr_q <= '0;
        end else if (state_q == ST_IDLE && req_valid) begin
            va_q    <= req_vaddr;
            daddr_q <= desc_addr_in;
        end
    end

    // Capture the decoded result when the descriptor arrives.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_q <= '0;
        end else if (state_q == ST_WAIT && mem_rsp_valid) begin
            rsp_q <= decoded;
        end
    end

    // Drive handshake outputs from the current state.
    always_comb begin
        req_ready    = (state_q == ST_IDLE);
        mem_rd_valid = (state_q == ST_FETCH);
        rsp_valid    = (state_q == ST_RESP);
        mem_rd_addr  = daddr_q;
        held_vaddr   = va_q;
    end
endmodule

// File: rtl/flat_xlat.sv
// Top level of the flat page table translator. Wires the index unit,
// descriptor decoder and sequencer together. Configuration inputs are
// assumed static while a request is pending, except the table base,
// which is sampled at acceptance.
module flat_xlat
    import flat_xlat_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [31:0] cfg_table_base,
    input  logic [31:0] cfg_protect_addr,
    input  logic [31:0] cfg_ctrl,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic [31:0] req_vaddr,
    output logic        mem_rd_valid,
    input  logic        mem_rd_ready,
    output logic [31:0] mem_rd_addr,
    output logic        mem_rd_coherent,
    input  logic        mem_rsp_valid,
    input  logic [31:0] mem_rsp_data,
    input  logic        mem_rsp_err,
    output logic        rsp_valid,
    input  logic        rsp_ready,
    output logic [31:0] rsp_paddr,
    output logic        rsp_fault,
    output logic [1:0]  rsp_kind,
    output logic        rsp_nonsec
);
    logic [ADDR_W-1:0] desc_addr;
    logic [ADDR_W-1:0] held_vaddr;
    xlat_result_t      decoded;
    xlat_result_t      rsp_q;

    flat_pt_index #(
        .ADDR_W     (ADDR_W),
        .PAGE_SHIFT (PAGE_SHIFT),
        .DESC_BYTES (DESC_BYTES)
    ) i_index (
        .table_base (cfg_table_base),
        .vaddr      (req_vaddr),
        .desc_addr  (desc_addr)
    );

    flat_pt_decode #(
        .A_W   (ADDR_W),
        .D_W   (DESC_W),
        .PSH   (PAGE_SHIFT),
        .ALIGN (PROTECT_ALIGN)
    ) i_decode (
        .desc         (mem_rsp_data),
        .rd_err       (mem_rsp_err),
        .vaddr        (held_vaddr),
        .protect_addr (cfg_protect_addr),
        .pmode        (cfg_ctrl[PMODE_LSB+1:PMODE_LSB]),
        .result       (decoded)
    );

    flat_pt_seq #(
        .A_W (ADDR_W)
    ) i_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .req_ready     (req_ready),
        .req_vaddr     (req_vaddr),
        .desc_addr_in  (desc_addr),
        .held_vaddr    (held_vaddr),
        .mem_rd_valid  (mem_rd_valid),
        .mem_rd_ready  (mem_rd_ready),
        .mem_rd_addr   (mem_rd_addr),
        .mem_rsp_valid (mem_rsp_valid),
        .decoded       (decoded),
        .rsp_valid     (rsp_valid),
        .rsp_ready     (rsp_ready),
        .rsp_q         (rsp_q)
    );

    // Present the registered result and the coherent-fetch flag.
    always_comb begin
        rsp_paddr       = rsp_q.paddr;
        rsp_kind        = rsp_q.kind;
        rsp_fault       = (rsp_q.kind != FK_NONE);
        rsp_nonsec      = rsp_q.nonsec;
        mem_rd_coherent = cfg_ctrl[COHERENT_BIT];
    end
endmodule

// File: rtl/flat_xlat_chk.sv
// Protocol and result checks for flat_xlat, attached by bind.
module flat_xlat_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_ready,
    input logic        mem_rd_valid,
    input logic        mem_rd_ready,
    input logic [31:0] mem_rd_addr,
    input logic        rsp_valid,
    input logic        rsp_ready,
    input logic [31:0] rsp_paddr,
    input logic        rsp_fault,
    input logic [1:0]  rsp_kind,
    input logic        rsp_nonsec,
    input logic [31:0] held_vaddr
);
    p_reset_idle_r1: assert property (@(posedge clk)
        !rst_n |=> (req_ready && !rsp_valid && !mem_rd_valid));

    p_rd_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_valid && !mem_rd_ready) |=> (mem_rd_valid && $stable(mem_rd_addr)));

    p_one_phase_r8: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!mem_rd_valid && !rsp_valid));

    p_no_reread_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_valid && mem_rd_ready) |=> !mem_rd_valid);

    p_rsp_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_paddr)
            && $stable(rsp_kind) && $stable(rsp_nonsec)));

    p_kind_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_fault == (rsp_kind != 2'd0)) && (rsp_kind != 2'd3));

    p_fault_secure_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault) |-> !rsp_nonsec);

    p_offset_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_fault) |-> (rsp_paddr[11:0] == held_vaddr[11:0]));
endmodule

bind flat_xlat flat_xlat_chk i_flat_xlat_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_ready    (req_ready),
    .mem_rd_valid (mem_rd_valid),
    .mem_rd_ready (mem_rd_ready),
    .mem_rd_addr  (mem_rd_addr),
    .rsp_valid    (rsp_valid),
    .rsp_ready    (rsp_ready),
    .rsp_paddr    (rsp_paddr),
    .rsp_fault    (rsp_fault),
    .rsp_kind     (rsp_kind),
    .rsp_nonsec   (rsp_nonsec),
    .held_vaddr   (held_vaddr)
);

// File: tb/test_flat_xlat.sv
module test_flat_xlat;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] cfg_table_base = '0;
    logic [31:0] cfg_protect_addr = '0;
    logic [31:0] cfg_ctrl = '0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic        mem_rd_valid;
    logic        mem_rd_ready = 1'b0;
    logic [31:0] mem_rd_addr;
    logic        mem_rd_coherent;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;
    logic        mem_rsp_err = 1'b0;
    logic        rsp_valid;
    logic        rsp_ready = 1'b0;
    logic [31:0] rsp_paddr;
    logic        rsp_fault;
    logic [1:0]  rsp_kind;
    logic        rsp_nonsec;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    flat_xlat i_flat_xlat (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    // Model of the redirect address, taken from R6.
    function automatic logic [31:0] prot_model(input logic [31:0] va);
        logic [31:0] b;
        b = cfg_protect_addr & 32'hFFFF_FF80;
        if (cfg_ctrl[6]) b = b + 32'd128;
        if (cfg_ctrl[5]) b = b + {25'd0, va[6:0]};
        return b;
    endfunction

    task automatic translate(input logic [31:0] va, input logic [31:0] desc, input bit err,
                             input int rd_wait, input int rsp_wait, input bit meddle);
        logic [31:0] exp_addr, exp_pa, saved_base;
        logic [1:0]  exp_kind;
        logic        exp_ns;
        exp_addr = cfg_table_base + (32'(va[31:12]) * 32'd4);
        if (err) begin exp_kind = 2'd2; exp_pa = prot_model(va); exp_ns = 1'b0; end
        else if (!desc[1]) begin exp_kind = 2'd1; exp_pa = prot_model(va); exp_ns = 1'b0; end
        else begin exp_kind = 2'd0; exp_pa = {desc[31:12], va[11:0]}; exp_ns = desc[3]; end
        saved_base = cfg_table_base;
        @(negedge clk);
        chk("R8 idle ready", 32'(req_ready), 32'd1);
        req_valid = 1'b1; req_vaddr = va;
        @(negedge clk);
        req_valid = meddle;
        if (meddle) begin
            req_vaddr = ~va;
            cfg_table_base = saved_base ^ 32'h0F00_0000;
        end
        chk("R8 busy", 32'(req_ready), 32'd0);
        for (int i = 0; i < rd_wait; i++) begin
            @(negedge clk);
            chk("R8 read held", 32'(mem_rd_valid), 32'd1);
        end
        chk("R8 read valid", 32'(mem_rd_valid), 32'd1);
        chk(meddle ? "R10 read addr" : "R2 read addr", mem_rd_addr, exp_addr);
        chk("R2 coherent", 32'(mem_rd_coherent), 32'(cfg_ctrl[8]));
        mem_rd_ready = 1'b1;
        @(negedge clk);
        mem_rd_ready = 1'b0;
        chk("R8 single read", 32'(mem_rd_valid), 32'd0);
        repeat (2) @(negedge clk);
        chk("R8 no reissue", 32'(mem_rd_valid), 32'd0);
        mem_rsp_valid = 1'b1; mem_rsp_data = desc; mem_rsp_err = err;
        @(negedge clk);
        mem_rsp_valid = 1'b0; mem_rsp_data = '0; mem_rsp_err = 1'b0;
        chk("R3 rsp valid", 32'(rsp_valid), 32'd1);
        chk(exp_kind == 2'd0 ? "R3 paddr" : "R6 redirect", rsp_paddr, exp_pa);
        chk(exp_kind == 2'd2 ? "R7 kind" : "R5 kind", 32'(rsp_kind), 32'(exp_kind));
        chk("R5 fault flag", 32'(rsp_fault), 32'(exp_kind != 2'd0));
        chk("R4 nonsec", 32'(rsp_nonsec), 32'(exp_ns));
        for (int i = 0; i < rsp_wait; i++) begin
            @(negedge clk);
            chk("R9 rsp held", 32'(rsp_valid), 32'd1);
            chk("R9 paddr held", rsp_paddr, exp_pa);
        end
        chk("R8 busy in resp", 32'(req_ready), 32'd0);
        req_valid = 1'b0;
        cfg_table_base = saved_base;
        rsp_ready = 1'b1;
        @(negedge clk);
        rsp_ready = 1'b0;
        chk("R8 rsp taken", 32'(rsp_valid), 32'd0);
        chk("R8 ready again", 32'(req_ready), 32'd1);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 req_ready", 32'(req_ready), 32'd1);
        chk("R1 rsp_valid", 32'(rsp_valid), 32'd0);
        chk("R1 mem_rd_valid", 32'(mem_rd_valid), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after release", 32'(req_ready), 32'd1);
    endtask

    task automatic t_valid_maps();
        cfg_table_base = 32'h8000_0000;
        cfg_ctrl = 32'h0000_0100;
        translate(32'h1234_5ABC, 32'h4567_800A, 1'b0, 0, 0, 1'b0);
        cfg_table_base = 32'h1000_0000;
        cfg_ctrl = 32'h0000_0000;
        translate(32'hFFFF_F001, 32'h0ABC_D002, 1'b0, 0, 0, 1'b0);
        translate(32'h0000_0FFF, 32'hFFFF_F00A, 1'b0, 0, 0, 1'b0);
    endtask

    task automatic t_protect_modes();
        cfg_protect_addr = 32'h2000_0045;
        for (int m = 0; m < 4; m++) begin
            cfg_ctrl = 32'(m) << 5;
            translate(32'h0000_1071, 32'h0000_0000, 1'b0, 0, 0, 1'b0);
        end
        cfg_ctrl = 32'h0000_0120;
        translate(32'h7654_3F7F, 32'hFFFF_FFFD, 1'b0, 0, 0, 1'b0);
    endtask

    task automatic t_walk_error();
        cfg_protect_addr = 32'h3000_0100;
        cfg_ctrl = 32'h0000_0060;
        translate(32'h0ABC_D123, 32'h5555_500A, 1'b1, 0, 0, 1'b0);
    endtask

    task automatic t_stalls_and_meddle();
        cfg_table_base = 32'h4000_0000;
        cfg_ctrl = 32'h0000_0100;
        translate(32'h0020_3456, 32'h9999_900A, 1'b0, 3, 3, 1'b1);
    endtask

    initial begin
        t_reset();
        t_valid_maps();
        t_protect_modes();
        t_walk_error();
        t_stalls_and_meddle();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual running expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule